// File: doc/BRIEF.md
# Dual Timer / Event Counter

This block holds two count channels, each with a 16-bit count register. Each channel counts machine cycles, which makes it a timer, or counts falling edges on its own external pin, which makes it an event counter. A machine cycle is six oscillator clocks long, and a pacing divider inside the block marks the end of each machine cycle. All counting happens only on those boundaries.

One 8-bit mode register sets up both channels. For each channel it holds a gate enable, a source select and a two-bit mode. The four modes are:

- a 13-bit count;
- a full 16-bit count;
- an 8-bit count that reloads itself from the high byte;
- a split mode, in which channel 0 becomes two independent 8-bit counters and channel 1 stands still.

A channel counts only while its run input is high. When its gate bit is set, it also needs its gate pin to be high. Every rollover sets a sticky overflow flag. Software clears a flag by writing a one to it. A small register port, addressed by `addr`, writes and reads the mode register, the four count bytes and the flags.

Top module: `dual_tmr_ctr`

## Requirements
- R1: The pacing divider starts from reset, and its first boundary falls on the 6th rising clock edge after reset is released; one falls on every 6th edge after that. With the source select at 0, an enabled channel adds exactly one per boundary, so a run window of 6*K clocks adds exactly K. Counts change only on a boundary or on a register write.
- R2: The register map is: addr 0 is the mode register, addr 1 and 2 are the low and high bytes of channel 0, addr 3 and 4 are the low and high bytes of channel 1, and addr 5 holds the flags (bit 0 for channel 0, bit 1 for channel 1). `rd_data` shows the addressed register one clock after `addr` is applied. A write with `wr_en` high takes effect on that clock edge. The mode register is written and read back as a whole byte. Its bit 7 is the gate of channel 1, bit 6 is the source of channel 1, bits 5:4 are the mode of channel 1, bit 3 is the gate of channel 0, bit 2 is the source of channel 0, and bits 1:0 are the mode of channel 0.
- R3: Mode 1 counts over all 16 bits. A step from 0xFFFF goes to 0x0000 and sets the channel's flag.
- R4: Mode 0 counts over 13 bits, formed by the high byte and bits 4:0 of the low byte. Bits 7:5 of the low byte stay as they are. A step from the all-ones value goes to zero and sets the flag.
- R5: Mode 2 counts over the low byte only. A step from 0xFF loads the high byte into the low byte and sets the flag. The high byte never changes by counting.
- R6: A channel counts only when its run input is 1 and either its gate bit is 0 or its gate pin is 1. Otherwise its count holds.
- R7: With the source select at 1, the pin is sampled once per boundary. It counts one for each pair of consecutive samples that reads high and then low. Each falling edge whose high and low levels last at least 12 clocks each is counted exactly once.
- R8: Suppose a counter pin falls just after a boundary. The increment then lands on the second boundary after that, 12 clocks later, and `rd_data` shows it one clock after that.
- R9: With channel 0 in mode 3, its low byte is an 8-bit counter under channel 0's own controls. Its high byte is an 8-bit timer enabled by `run[1]` alone, and its rollover sets flag 1. The rollover of the low byte sets flag 0.
- R10: Channel 1 in mode 3 holds its count whatever its inputs are.
- R11: A flag stays set until a write to addr 5 with a one in its bit position. A zero in that bit leaves the flag as it is.
- R12: After reset the mode register, all count bytes and both flags read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| ext_in | input | 2 | Event pins, one per channel |
| gate_in | input | 2 | Gate pins, one per channel |
| run | input | 2 | Run enables, one per channel |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| ovf | output | 2 | Sticky overflow flags |

## Verification
Boundaries fall on the 6th, 12th, ... edge after reset, so the bench counts clock edges itself and always knows where the next boundary lies. For timer results, the bench holds run windows of exactly 6*K clocks, which contain exactly K boundaries whatever their phase. It reads the count only after the window closes and allows the one-clock read latency. For event counts, every pin level is held for 12 clocks, and the bench waits several machine cycles before it reads. The latency check drops the pin just after a known boundary. It then expects the old value on the read port through edge 12 and the new value after edge 13.

// File: rtl/dtc_pkg.sv
package dtc_pkg;
  typedef enum logic [1:0] {
    MD_13B   = 2'd0,
    MD_16B   = 2'd1,
    MD_RLD8  = 2'd2,
    MD_SPLIT = 2'd3
  } cnt_mode_e;

  typedef struct packed {
    logic      gated;
    logic      evt_src;
    cnt_mode_e md;
  } chan_cfg_t;

  localparam int unsigned RA_MODE = 0;
  localparam int unsigned RA_LO0  = 1;
  localparam int unsigned RA_FLAG = 5;
endpackage

// File: rtl/dtc_mc_pace.sv
module dtc_mc_pace #(
  parameter int unsigned MC_LEN = 6
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int unsigned PW = (MC_LEN > 1) ? $clog2(MC_LEN) : 1;
  localparam logic [PW-1:0] LAST = PW'(MC_LEN - 1);
  localparam logic [PW-1:0] ONE  = PW'(1);

  logic [PW-1:0] ph;

  always_ff @(posedge clk) begin
    if (rst)             ph <= '0;
    else if (ph == LAST) ph <= '0;
    else                 ph <= ph + ONE;
  end

  assign tick = (ph == LAST);
endmodule

// File: rtl/dtc_fall_det.sv
module dtc_fall_det #(
  parameter int unsigned SYNC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic pin,
  output logic fall
);
  logic [SYNC-1:0] sy;
  logic            smp;
  logic            fall_q;

  generate
    if (SYNC > 1) begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) sy <= '0;
        else     sy <= {sy[SYNC-2:0], pin};
      end
    end else begin : g_single
      always_ff @(posedge clk) begin
        if (rst) sy <= '0;
        else     sy <= pin;
      end
    end
  endgenerate

  // one sample per machine cycle; high then low marks a falling edge,
  // which is consumed on the following boundary
  always_ff @(posedge clk) begin
    if (rst) begin
      smp    <= 1'b0;
      fall_q <= 1'b0;
    end else if (tick) begin
      smp    <= sy[SYNC-1];
      fall_q <= smp & ~sy[SYNC-1];
    end
  end

  assign fall = fall_q;
endmodule

// File: rtl/dtc_chan.sv
module dtc_chan
  import dtc_pkg::*;
#(
  parameter int unsigned BW    = 8,
  parameter int unsigned PRE   = 5,
  parameter bit          SPLIT = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          en_lo,
  input  logic          en_hi,
  input  cnt_mode_e     md,
  input  logic          wr_lo,
  input  logic          wr_hi,
  input  logic [BW-1:0] wdata,
  output logic [BW-1:0] lo,
  output logic [BW-1:0] hi,
  output logic          ovf_lo,
  output logic          ovf_hi
);
  localparam logic [BW-1:0]     ONE_B = BW'(1);
  localparam logic [BW+PRE-1:0] ONE_S = (BW + PRE)'(1);
  localparam logic [2*BW-1:0]   ONE_F = (2 * BW)'(1);

  logic [BW+PRE-1:0] short_v;
  logic [2*BW-1:0]   full_v;

  assign short_v = {hi, lo[PRE-1:0]};
  assign full_v  = {hi, lo};

  always_ff @(posedge clk) begin
    if (rst) begin
      lo     <= '0;
      hi     <= '0;
      ovf_lo <= 1'b0;
      ovf_hi <= 1'b0;
    end else begin
      ovf_lo <= 1'b0;
      ovf_hi <= 1'b0;
      if (tick && en_lo) begin
        case (md)
          MD_13B: begin
            {hi, lo[PRE-1:0]} <= short_v + ONE_S;
            if (&short_v) ovf_lo <= 1'b1;
          end
          MD_16B: begin
            {hi, lo} <= full_v + ONE_F;
            if (&full_v) ovf_lo <= 1'b1;
          end
          MD_RLD8: begin
            if (&lo) begin
              lo     <= hi;
              ovf_lo <= 1'b1;
            end else begin
              lo <= lo + ONE_B;
            end
          end
          default: begin
            if (SPLIT) begin
              lo <= lo + ONE_B;
              if (&lo) ovf_lo <= 1'b1;
            end
          end
        endcase
      end
      if (SPLIT && md == MD_SPLIT && tick && en_hi) begin
        hi <= hi + ONE_B;
        if (&hi) ovf_hi <= 1'b1;
      end
      if (wr_lo) lo <= wdata;
      if (wr_hi) hi <= wdata;
    end
  end
endmodule

// File: rtl/dual_tmr_ctr.sv
module dual_tmr_ctr
  import dtc_pkg::*;
#(
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned MC_LEN   = 6,
  parameter int unsigned PRE_BITS = 5,
  parameter int unsigned SYNC     = 2,
  parameter int unsigned AW       = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         ext_in,
  input  logic [1:0]         gate_in,
  input  logic [1:0]         run,
  input  logic               wr_en,
  input  logic [AW-1:0]      addr,
  input  logic [CNT_W/2-1:0] wdata,
  output logic [CNT_W/2-1:0] rd_data,
  output logic [1:0]         ovf
);
  localparam int unsigned DW = CNT_W / 2;
  localparam logic [AW-1:0] A_MODE = AW'(RA_MODE);
  localparam logic [AW-1:0] A_FLAG = AW'(RA_FLAG);

  logic            tick;
  logic [7:0]      mode_q;
  chan_cfg_t       cfg [2];
  logic [1:0]      fall, en_lo, lvl_ok, ovl, ovh;
  logic [DW-1:0]   lo_v [2];
  logic [DW-1:0]   hi_v [2];
  logic [1:0]      flag_q, flag_set, flag_clr;
  logic            split0;
  logic [CNT_W-1:0] cnt0_w, cnt1_w;

  dtc_mc_pace #(.MC_LEN(MC_LEN)) u_pace (.clk(clk), .rst(rst), .tick(tick));

  assign cfg[0] = chan_cfg_t'(mode_q[3:0]);
  assign cfg[1] = chan_cfg_t'(mode_q[7:4]);

  always_ff @(posedge clk) begin
    if (rst)                         mode_q <= '0;
    else if (wr_en && addr == A_MODE) mode_q <= 8'(wdata);
  end

  genvar g;
  generate
    for (g = 0; g < 2; g++) begin : g_ch
      localparam logic [AW-1:0] A_LO = AW'(RA_LO0 + 2 * g);
      localparam logic [AW-1:0] A_HI = AW'(RA_LO0 + 2 * g + 1);
      logic en_hi_w;

      dtc_fall_det #(.SYNC(SYNC)) u_fd (
        .clk(clk), .rst(rst), .tick(tick), .pin(ext_in[g]), .fall(fall[g])
      );

      assign lvl_ok[g] = run[g] & (~cfg[g].gated | gate_in[g]);
      assign en_lo[g]  = lvl_ok[g] & (cfg[g].evt_src ? fall[g] : 1'b1);
      assign en_hi_w   = (g == 0) ? run[1] : 1'b0;

      dtc_chan #(.BW(DW), .PRE(PRE_BITS), .SPLIT(g == 0)) u_ch (
        .clk(clk), .rst(rst), .tick(tick),
        .en_lo(en_lo[g]), .en_hi(en_hi_w), .md(cfg[g].md),
        .wr_lo(wr_en && addr == A_LO), .wr_hi(wr_en && addr == A_HI),
        .wdata(wdata), .lo(lo_v[g]), .hi(hi_v[g]),
        .ovf_lo(ovl[g]), .ovf_hi(ovh[g])
      );
    end
  endgenerate

  // split mode hands flag 1 to the upper half of channel 0
  assign split0      = (cfg[0].md == MD_SPLIT);
  assign flag_set[0] = ovl[0];
  assign flag_set[1] = split0 ? ovh[0] : (ovl[1] | ovh[1]);
  assign flag_clr    = (wr_en && addr == A_FLAG) ? wdata[1:0] : 2'b00;

  always_ff @(posedge clk) begin
    if (rst) flag_q <= '0;
    else     flag_q <= (flag_q & ~flag_clr) | flag_set;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else begin
      case (addr)
        AW'(0):  rd_data <= DW'(mode_q);
        AW'(1):  rd_data <= lo_v[0];
        AW'(2):  rd_data <= hi_v[0];
        AW'(3):  rd_data <= lo_v[1];
        AW'(4):  rd_data <= hi_v[1];
        AW'(5):  rd_data <= DW'(flag_q);
        default: rd_data <= '0;
      endcase
    end
  end

  assign ovf    = flag_q;
  assign cnt0_w = {hi_v[0], lo_v[0]};
  assign cnt1_w = {hi_v[1], lo_v[1]};
endmodule

// File: rtl/dtc_chk.sv
module dtc_chk #(
  parameter int unsigned CW = 16,
  parameter int unsigned AW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          tick,
  input logic          wr_en,
  input logic [AW-1:0] addr,
  input logic [1:0]    wd,
  input logic [1:0]    run,
  input logic [1:0]    m0,
  input logic [1:0]    m1,
  input logic [1:0]    ovf,
  input logic [CW-1:0] c0,
  input logic [CW-1:0] c1
);
  localparam logic [AW-1:0] A_FLAG = AW'(5);

  AST_TICK_GAP: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick); // R1
  AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!tick && !wr_en) |=> ($stable(c0) && $stable(c1))); // R1
  AST_RUN_OFF_HOLD: assert property (@(posedge clk) disable iff (rst)
    (run == 2'b00 && !wr_en) |=> ($stable(c0) && $stable(c1))); // R6
  AST_RELOAD_HI_KEEP: assert property (@(posedge clk) disable iff (rst)
    (m0 == 2'd2 && !wr_en) |=> $stable(c0[CW-1:CW/2])); // R5
  AST_CH1_SPLIT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (m1 == 2'd3 && !wr_en) |=> $stable(c1)); // R10
  AST_FLAG0_STICKY: assert property (@(posedge clk) disable iff (rst)
    (ovf[0] && !(wr_en && addr == A_FLAG && wd[0])) |=> ovf[0]); // R11
  AST_FLAG1_STICKY: assert property (@(posedge clk) disable iff (rst)
    (ovf[1] && !(wr_en && addr == A_FLAG && wd[1])) |=> ovf[1]); // R11
endmodule

bind dual_tmr_ctr dtc_chk #(.CW(CNT_W), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .addr(addr),
  .wd(wdata[1:0]), .run(run), .m0(mode_q[1:0]), .m1(mode_q[5:4]),
  .ovf(ovf), .c0(cnt0_w), .c1(cnt1_w)
);

// File: tb/sim_dual_tmr_ctr.sv
module sim_dual_tmr_ctr;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] ext_in = '0, gate_in = '0, run = '0;
  logic       wr_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rd_data;
  logic [1:0] ovf;
  int n_chk = 0, n_fail = 0, ecnt = 0;

  always #5 clk = ~clk;

  dual_tmr_ctr u0 (.clk(clk), .rst(rst), .ext_in(ext_in), .gate_in(gate_in),
    .run(run), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rd_data(rd_data), .ovf(ovf));

  always @(posedge clk) ecnt <= rst ? 0 : ecnt + 1;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk); addr = 3'(a); wdata = 8'(d); wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(int a, output int v);
    @(negedge clk); addr = 3'(a);
    @(negedge clk); v = int'(rd_data);
  endtask

  task automatic set16(int ch, int v);
    wr(1 + 2 * ch, v & 8'hFF); wr(2 + 2 * ch, (v >> 8) & 8'hFF);
  endtask

  task automatic get16(int ch, output int v);
    int l, h;
    rd(1 + 2 * ch, l); rd(2 + 2 * ch, h); v = (h << 8) | l;
  endtask

  task automatic run_win(logic [1:0] m, int k);
    @(negedge clk); run = m;
    repeat (6 * k) @(negedge clk);
    run = 2'b00;
  endtask

  task automatic pulses(int ch, int cnt);
    for (int i = 0; i < cnt; i++) begin
      ext_in[ch] = 1'b1; repeat (12) @(negedge clk);
      ext_in[ch] = 1'b0; repeat (12) @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int v;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    for (int a = 0; a < 6; a++) begin
      rd(a, v); chk("R12 reset register", v, 0);
    end
    chk("R12 reset flags", int'(ovf), 0);

    wr(0, 8'hA7); rd(0, v); chk("R2 mode readback", v, 8'hA7);

    // R1 sweep on channel 1 (mode 1 timer, mode byte 0x10)
    wr(0, 8'h10);
    for (int k = 1; k <= 8; k++) begin
      set16(1, 16'h00F0);
      run_win(2'b10, k);
      get16(1, v); chk("R1 timer window", v, 16'h00F0 + k);
    end

    // R3 16-bit wrap on channel 0
    wr(0, 8'h01); set16(0, 16'hFFFE);
    run_win(2'b01, 3);
    get16(0, v); chk("R3 wrap value", v, 16'h0001);
    @(negedge clk); chk("R3 flag set", int'(ovf[0]), 1);

    // R11 write zero keeps, write one clears
    wr(5, 8'h00); rd(5, v); chk("R11 zero keeps flag", v, 1);
    wr(5, 8'h01); rd(5, v); chk("R11 one clears flag", v, 0);

    // R4 13-bit mode: low byte 0xFE, bits 7:5 stay 111
    wr(0, 8'h00); set16(0, 16'hFFFE);
    run_win(2'b01, 3);
    get16(0, v); chk("R4 13-bit wrap", v, 16'h00E1);
    @(negedge clk); chk("R4 flag set", int'(ovf[0]), 1);
    wr(5, 8'h03);

    // R5 reload mode
    wr(0, 8'h02); set16(0, 16'hF0FE);
    run_win(2'b01, 4);
    get16(0, v); chk("R5 reload sequence", v, 16'hF0F2);
    @(negedge clk); chk("R5 flag set", int'(ovf[0]), 1);
    wr(5, 8'h03);

    // R6 gating (gate bit 3 set, mode 1)
    wr(0, 8'h09); set16(0, 16'h0100);
    gate_in = 2'b00; run_win(2'b01, 4);
    get16(0, v); chk("R6 gate pin low holds", v, 16'h0100);
    gate_in = 2'b01; run_win(2'b01, 4);
    get16(0, v); chk("R6 gate pin high counts", v, 16'h0104);
    gate_in = 2'b00;
    wr(0, 8'h01); run_win(2'b00, 4);
    get16(0, v); chk("R6 run low holds", v, 16'h0104);

    // R7 event counting on both channels
    wr(0, 8'h05); set16(0, 0);
    @(negedge clk); run = 2'b01;
    pulses(0, 3); repeat (30) @(negedge clk); run = 2'b00;
    get16(0, v); chk("R7 channel 0 falls", v, 3);
    wr(0, 8'h50); set16(1, 0);
    @(negedge clk); run = 2'b10;
    pulses(1, 5); repeat (30) @(negedge clk); run = 2'b00;
    get16(1, v); chk("R7 channel 1 falls", v, 5);

    // R8 latency from a fall just after a known boundary
    wr(0, 8'h05); set16(0, 0);
    ext_in[0] = 1'b1;
    @(negedge clk); addr = 3'd1; run = 2'b01;
    repeat (30) @(negedge clk);
    do @(negedge clk); while (ecnt % 6 != 0);
    ext_in[0] = 1'b0;
    repeat (6) @(negedge clk);
    chk("R8 not yet at first boundary", int'(rd_data), 0);
    repeat (6) @(negedge clk);
    chk("R8 old value through edge 12", int'(rd_data), 0);
    @(negedge clk);
    chk("R8 new value after edge 13", int'(rd_data), 1);
    run = 2'b00;

    // R9 split mode on channel 0
    wr(5, 8'h03); wr(0, 8'h03); set16(0, 16'hFDFE); set16(1, 0);
    run_win(2'b01, 3);
    get16(0, v); chk("R9 low half counts alone", v, 16'hFD01);
    @(negedge clk); chk("R9 low rollover flag", int'(ovf), 1);
    run_win(2'b10, 4);
    get16(0, v); chk("R9 high half under run1", v, 16'h0101);
    @(negedge clk); chk("R9 high rollover sets flag 1", int'(ovf), 3);
    wr(5, 8'h03);

    // R10 channel 1 in mode 3 holds, channel 0 mode 1 keeps counting
    wr(0, 8'h31); set16(1, 16'h1234); set16(0, 0);
    run_win(2'b11, 5);
    get16(1, v); chk("R10 channel 1 holds", v, 16'h1234);
    get16(0, v); chk("R10 channel 0 counts", v, 5);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule